// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block chooses the settings that steer a clock synthesizer: a 4-bit frequency code, a divider pair (N, M), a spread enable and a spread type. When reset is released it captures the reference-select pin, the three frequency pins and the spread pin once into shadow bits. A software-control bit then decides whether the live pins or the shadow bits set the code and the spread enable. The spread type always comes from its own register bit.

By default the divider pair is looked up from a fixed table indexed by the effective code. A divider-override bit replaces the table pair with a programmed 10-bit N and 6-bit M. The synthesizer's VCO ratio is (N+8)/(M+2) times the reference. A readback byte always mirrors the live pin levels. A one-cycle pulse marks every change of the effective code or divider pair.

Top module: `fsel_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are code 0, N 72, M 3, spread enable 0, spread type 0, readback 0 and change pulse 0.
- R2: On the first rising clock edge with `rst_n` high, the shadow bits capture {`pin_ref_sel`, `pin_fs`, `pin_spread`}. Pin changes after that edge never reach the shadow bits.
- R3: While software control is 0, `freq_code_o` = {`pin_ref_sel`, `pin_fs`} and `spread_en_o` = `pin_spread`, with one clock of latency.
- R4: The control write `ctl_wdata` has this layout: [6:3] code ({ref-select, FS2, FS1, FS0}), [2] spread enable, [1] software control, [0] spread type. Bits [6:2] update the shadow bits only if software control was already 1 before that write. Otherwise they are ignored.
- R5: While software control is 1, the code and the spread enable come from the shadow bits, and the pins have no effect on them.
- R6: `spread_type_o` (0 = down, 1 = center) takes `ctl_wdata[0]` on every control write, whatever the software control setting.
- R7: `pin_readback_o` is {`pin_ref_sel`, `pin_fs[2:0]`, `pin_spread`, 3'b000} with one clock of latency, in every mode.
- R8: With the override off, the divider pair depends on the effective code. Frequency f is taken from code[2:0] = 0..7 as 100, 125, 133.33, 166.67, 200, 266, 333 and 400 MHz. For code[3] = 1 (14.31818 MHz reference), M = 5 and N = round(28·f/14.31818) − 8. For code[3] = 0 (25 MHz reference), M = 3 and N = round(20·f/25) − 8.
- R9: A divider write (`mn_wr`) sets the override to `mn_wen`. While the override is 1, `div_n_o`/`div_m_o` equal the written N/M, visible on the cycle after the write.
- R10: `config_changed_o` is 1 for exactly the cycles in which {`freq_code_o`, `div_n_o`, `div_m_o`} differs from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_ref_sel | input | 1 | Reference-select pin (1 = 14.31818 MHz, 0 = 25 MHz) |
| pin_fs | input | 3 | Frequency select pins FS2..FS0 |
| pin_spread | input | 1 | Spread enable pin |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 7 | Control write data (layout in R4) |
| mn_wr | input | 1 | Divider write strobe |
| mn_wen | input | 1 | Divider override enable written with `mn_wr` |
| mn_n_wdata | input | 10 | Programmed N |
| mn_m_wdata | input | 6 | Programmed M |
| freq_code_o | output | 4 | Effective frequency code |
| div_n_o | output | 10 | Effective N divider |
| div_m_o | output | 6 | Effective M divider |
| spread_en_o | output | 1 | Effective spread enable |
| spread_type_o | output | 1 | Spread type |
| pin_readback_o | output | 8 | Live pin readback byte |
| config_changed_o | output | 1 | One-cycle pulse on a code or divider change |

## Verification
Each result is due on the clock edge that follows its cause. This holds for the code, the dividers, the spread bits and the readback byte, whether the cause is a pin change or a register write. The change pulse is due on that same edge. The shadow capture happens on the first edge after reset is released. Its effect is seen only after a later write enables software control. Inputs change on falling edges, and the bench model advances on each rising edge. Every output is compared against the model on the following falling edge, which is exactly one register stage after the stimulus.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int CODE_W   = 4;
    localparam int FS_W     = 3;
    localparam int STRAP_W  = CODE_W + 1;
    localparam int DIV_N_W  = 10;
    localparam int DIV_M_W  = 6;

    // divider table: 14.31818 MHz reference uses M=5, 25 MHz reference uses M=3
    function automatic int tbl_n(input logic [CODE_W-1:0] code);
        int n;
        if (code[CODE_W-1]) begin
            case (code[FS_W-1:0])
                3'd0: n = 188;
                3'd1: n = 236;
                3'd2: n = 253;
                3'd3: n = 318;
                3'd4: n = 383;
                3'd5: n = 512;
                3'd6: n = 643;
                default: n = 774;
            endcase
        end else begin
            case (code[FS_W-1:0])
                3'd0: n = 72;
                3'd1: n = 92;
                3'd2: n = 99;
                3'd3: n = 125;
                3'd4: n = 152;
                3'd5: n = 205;
                3'd6: n = 258;
                default: n = 312;
            endcase
        end
        return n;
    endfunction

    function automatic int tbl_m(input logic ref_bit);
        return ref_bit ? 5 : 3;
    endfunction

endpackage

// File: rtl/fsel_strap_shadow.sv
module fsel_strap_shadow #(
    parameter int W = fsel_pkg::STRAP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] shadow_nx
);
    typedef struct packed {
        logic         sampled;
        logic [W-1:0] val;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!sh_q.sampled) begin
            sh_d.sampled = 1'b1;
            sh_d.val     = pin_val;
        end else if (wr_en) begin
            sh_d.val     = wr_val;
        end
        shadow_nx = sh_d.val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/fsel_div_table.sv
module fsel_div_table #(
    parameter int CODE_W = fsel_pkg::CODE_W,
    parameter int N_W    = fsel_pkg::DIV_N_W,
    parameter int M_W    = fsel_pkg::DIV_M_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [N_W-1:0]    tbl_n,
    output logic [M_W-1:0]    tbl_m
);
    always_comb begin
        tbl_n = N_W'(fsel_pkg::tbl_n(code));
        tbl_m = M_W'(fsel_pkg::tbl_m(code[CODE_W-1]));
    end
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl #(
    parameter int N_W = fsel_pkg::DIV_N_W,
    parameter int M_W = fsel_pkg::DIV_M_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pin_ref_sel,
    input  logic [2:0]     pin_fs,
    input  logic           pin_spread,
    input  logic           ctl_wr,
    input  logic [6:0]     ctl_wdata,
    input  logic           mn_wr,
    input  logic           mn_wen,
    input  logic [N_W-1:0] mn_n_wdata,
    input  logic [M_W-1:0] mn_m_wdata,
    output logic [3:0]     freq_code_o,
    output logic [N_W-1:0] div_n_o,
    output logic [M_W-1:0] div_m_o,
    output logic           spread_en_o,
    output logic           spread_type_o,
    output logic [7:0]     pin_readback_o,
    output logic           config_changed_o
);
    localparam int CODE_W  = fsel_pkg::CODE_W;
    localparam int STRAP_W = fsel_pkg::STRAP_W;
    localparam int RB_W    = 8;
    localparam int RB_PAD  = RB_W - STRAP_W;
    localparam int B_SW    = 1;
    localparam int B_TYPE  = 0;
    localparam logic [N_W-1:0] RST_N = N_W'(fsel_pkg::tbl_n('0));
    localparam logic [M_W-1:0] RST_M = M_W'(fsel_pkg::tbl_m(1'b0));

    typedef struct packed {
        logic              sw_ctl;
        logic              sp_type;
        logic              mn_en;
        logic [N_W-1:0]    mn_n;
        logic [M_W-1:0]    mn_m;
        logic [CODE_W-1:0] code;
        logic [N_W-1:0]    div_n;
        logic [M_W-1:0]    div_m;
        logic              sp_en;
        logic [RB_W-1:0]   readback;
        logic              changed;
    } st_t;

    st_t s_d, s_q;

    logic [STRAP_W-1:0] pin_bus;
    logic [STRAP_W-1:0] shadow_nx;
    logic [STRAP_W-1:0] eff_bus;
    logic               sw_nx;
    logic               shadow_wr;
    logic [N_W-1:0]     tbl_n;
    logic [M_W-1:0]     tbl_m;

    always_comb begin
        pin_bus   = {pin_ref_sel, pin_fs, pin_spread};
        shadow_wr = ctl_wr && s_q.sw_ctl;
        sw_nx     = ctl_wr ? ctl_wdata[B_SW] : s_q.sw_ctl;
        eff_bus   = sw_nx ? shadow_nx : pin_bus;
    end

    fsel_strap_shadow #(.W(STRAP_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_val   (pin_bus),
        .wr_en     (shadow_wr),
        .wr_val    (ctl_wdata[6:2]),
        .shadow_nx (shadow_nx)
    );

    fsel_div_table #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W)) u_table (
        .code  (eff_bus[STRAP_W-1:1]),
        .tbl_n (tbl_n),
        .tbl_m (tbl_m)
    );

    always_comb begin
        s_d = s_q;
        if (ctl_wr) begin
            s_d.sp_type = ctl_wdata[B_TYPE];
        end
        s_d.sw_ctl = sw_nx;
        if (mn_wr) begin
            s_d.mn_en = mn_wen;
            s_d.mn_n  = mn_n_wdata;
            s_d.mn_m  = mn_m_wdata;
        end
        s_d.code     = eff_bus[STRAP_W-1:1];
        s_d.sp_en    = eff_bus[0];
        s_d.div_n    = s_d.mn_en ? s_d.mn_n : tbl_n;
        s_d.div_m    = s_d.mn_en ? s_d.mn_m : tbl_m;
        s_d.readback = {pin_bus, {RB_PAD{1'b0}}};
        s_d.changed  = (s_d.code  != s_q.code)  ||
                       (s_d.div_n != s_q.div_n) ||
                       (s_d.div_m != s_q.div_m);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.div_n <= RST_N;
            s_q.div_m <= RST_M;
        end else begin
            s_q <= s_d;
        end
    end

    assign freq_code_o      = s_q.code;
    assign div_n_o          = s_q.div_n;
    assign div_m_o          = s_q.div_m;
    assign spread_en_o      = s_q.sp_en;
    assign spread_type_o    = s_q.sp_type;
    assign pin_readback_o   = s_q.readback;
    assign config_changed_o = s_q.changed;
endmodule

// File: rtl/fsel_ctrl_chk.sv
module fsel_ctrl_chk #(
    parameter int N_W = fsel_pkg::DIV_N_W,
    parameter int M_W = fsel_pkg::DIV_M_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pin_ref_sel,
    input logic [2:0]     pin_fs,
    input logic           pin_spread,
    input logic           ctl_wr,
    input logic [6:0]     ctl_wdata,
    input logic           mn_wr,
    input logic           mn_wen,
    input logic [N_W-1:0] mn_n_wdata,
    input logic [M_W-1:0] mn_m_wdata,
    input logic [3:0]     freq_code_o,
    input logic [N_W-1:0] div_n_o,
    input logic [M_W-1:0] div_m_o,
    input logic           spread_en_o,
    input logic           spread_type_o,
    input logic [7:0]     pin_readback_o,
    input logic           config_changed_o
);
    // R3
    hw_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[1]) |=>
            (spread_en_o == $past(pin_spread)) &&
            (freq_code_o == $past({pin_ref_sel, pin_fs})));

    // R6
    spread_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> spread_type_o == $past(ctl_wdata[0]));

    // R7
    readback_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pin_readback_o[7:3] == $past({pin_ref_sel, pin_fs, pin_spread}));

    // R7
    readback_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_readback_o[2:0] == 3'b000);

    // R9
    mn_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mn_wr && mn_wen) |=> (div_n_o == $past(mn_n_wdata)) && (div_m_o == $past(mn_m_wdata)));

    // R10
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        config_changed_o == ({freq_code_o, div_n_o, div_m_o} != $past({freq_code_o, div_n_o, div_m_o})));
endmodule

bind fsel_ctrl fsel_ctrl_chk #(.N_W(N_W), .M_W(M_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .pin_ref_sel      (pin_ref_sel),
    .pin_fs           (pin_fs),
    .pin_spread       (pin_spread),
    .ctl_wr           (ctl_wr),
    .ctl_wdata        (ctl_wdata),
    .mn_wr            (mn_wr),
    .mn_wen           (mn_wen),
    .mn_n_wdata       (mn_n_wdata),
    .mn_m_wdata       (mn_m_wdata),
    .freq_code_o      (freq_code_o),
    .div_n_o          (div_n_o),
    .div_m_o          (div_m_o),
    .spread_en_o      (spread_en_o),
    .spread_type_o    (spread_type_o),
    .pin_readback_o   (pin_readback_o),
    .config_changed_o (config_changed_o)
);

// File: tb/sim_fsel_ctrl.sv
`timescale 1ns/1ps
module sim_fsel_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_ref_sel = 1'b1;
    logic [2:0] pin_fs = 3'b010;
    logic       pin_spread = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic       mn_wr = 1'b0;
    logic       mn_wen = 1'b0;
    logic [9:0] mn_n_wdata = '0;
    logic [5:0] mn_m_wdata = '0;
    logic [3:0] freq_code_o;
    logic [9:0] div_n_o;
    logic [5:0] div_m_o;
    logic       spread_en_o, spread_type_o, config_changed_o;
    logic [7:0] pin_readback_o;

    int n_chk = 0;
    int n_bad = 0;
    bit run_cmp = 0;

    always #2 clk = ~clk;

    fsel_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_ref_sel(pin_ref_sel), .pin_fs(pin_fs),
        .pin_spread(pin_spread), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .mn_wr(mn_wr), .mn_wen(mn_wen), .mn_n_wdata(mn_n_wdata), .mn_m_wdata(mn_m_wdata),
        .freq_code_o(freq_code_o), .div_n_o(div_n_o), .div_m_o(div_m_o),
        .spread_en_o(spread_en_o), .spread_type_o(spread_type_o),
        .pin_readback_o(pin_readback_o), .config_changed_o(config_changed_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R8 rule: N from the target frequency and reference, by rounding
    function automatic real fs_mhz(input int fs);
        real f;
        case (fs)
            0: f = 100.0;   1: f = 125.0;   2: f = 133.33;  3: f = 166.67;
            4: f = 200.0;   5: f = 266.0;   6: f = 333.0;   default: f = 400.0;
        endcase
        return f;
    endfunction

    function automatic int exp_m(input int code);
        return (code >= 8) ? 5 : 3;
    endfunction

    function automatic int exp_n(input int code);
        real r;
        r = (code >= 8) ? 14.31818 : 25.0;
        return $rtoi(4.0 * fs_mhz(code % 8) * (exp_m(code) + 2) / r + 0.5) - 8;
    endfunction

    // behavioural reference model
    int  m_sh, m_sw, m_type, m_mnen, m_n, m_m;
    bit  m_sampled;
    int  e_code, e_n, e_m, e_sp, e_type, e_rb, e_chg;

    always @(posedge clk) begin
        int pins, eff, nc, nn, nm, old_sw;
        pins = {pin_ref_sel, pin_fs, pin_spread};
        if (!rst_n) begin
            m_sampled = 0; m_sh = 0; m_sw = 0; m_type = 0;
            m_mnen = 0; m_n = 0; m_m = 0;
            e_code = 0; e_n = exp_n(0); e_m = exp_m(0);
            e_sp = 0; e_type = 0; e_rb = 0; e_chg = 0;
        end else begin
            old_sw = m_sw;
            if (ctl_wr) begin
                m_sw = ctl_wdata[1];
                m_type = ctl_wdata[0];
            end
            if (!m_sampled) begin
                m_sh = pins;
                m_sampled = 1;
            end else if (ctl_wr && old_sw != 0) begin
                m_sh = ctl_wdata[6:2];
            end
            if (mn_wr) begin
                m_mnen = mn_wen; m_n = mn_n_wdata; m_m = mn_m_wdata;
            end
            eff = (m_sw != 0) ? m_sh : pins;
            nc = eff / 2;
            nn = (m_mnen != 0) ? m_n : exp_n(nc);
            nm = (m_mnen != 0) ? m_m : exp_m(nc);
            e_chg = (nc != e_code || nn != e_n || nm != e_m) ? 1 : 0;
            e_code = nc; e_n = nn; e_m = nm;
            e_sp = eff % 2;
            e_type = m_type;
            e_rb = pins * 8;
        end
    end

    always @(negedge clk) begin
        if (run_cmp) begin
            chk("R3/R5 code", freq_code_o, e_code);
            chk("R8 div_n", div_n_o, e_n);
            chk("R8 div_m", div_m_o, e_m);
            chk("R3/R5 spread_en", spread_en_o, e_sp);
            chk("R6 spread_type", spread_type_o, e_type);
            chk("R7 readback", pin_readback_o, e_rb);
            chk("R10 changed", config_changed_o, e_chg);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pins(input int code, input int sp);
        pin_ref_sel = code[3];
        pin_fs      = code[2:0];
        pin_spread  = sp[0];
    endtask

    task automatic ctl_write(input logic [6:0] v);
        ctl_wdata = v; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        run_cmp = 1;
        // R1 reset state
        chk("R1 code", freq_code_o, 0);
        chk("R1 n", div_n_o, 72);
        chk("R1 m", div_m_o, 3);
        chk("R1 readback", pin_readback_o, 0);
        chk("R1 changed", config_changed_o, 0);
        rst_n = 1'b1;
        @(negedge clk);                 // sampling edge has passed: pins 1010, spread 1
        chk("R2 code after sampling", freq_code_o, 10);
        chk("R8 n for 1010", div_n_o, 253);
        set_pins(0, 0);
        cyc(1);
        chk("R10 change pulse on pin change", config_changed_o, 1);
        // R3 hardware path over all codes
        for (int c = 0; c < 16; c++) begin
            set_pins(c, c % 2);
            cyc(2);
        end
        set_pins(3, 0);
        cyc(1);
        // R4 frequency bits ignored while software control was 0; enable control, center spread
        ctl_write({4'b0101, 1'b0, 1'b1, 1'b1});
        chk("R2 shadow keeps sampled code", freq_code_o, 10);
        chk("R4 spread_en from sampled pin", spread_en_o, 1);
        chk("R6 spread type center", spread_type_o, 1);
        // R4 now writable
        ctl_write({4'b0111, 1'b0, 1'b1, 1'b0});
        chk("R4 written code", freq_code_o, 7);
        chk("R8 n for 0111", div_n_o, 312);
        // R5 pins ignored
        set_pins(12, 1);
        cyc(3);
        chk("R5 code holds", freq_code_o, 7);
        chk("R5 spread_en holds", spread_en_o, 0);
        chk("R7 readback live", pin_readback_o, 8'b1100_1000);
        // back to hardware
        ctl_write(7'b0000000);
        chk("R3 code follows pins", freq_code_o, 12);
        // R9 divider override
        mn_wen = 1'b1; mn_n_wdata = 10'd500; mn_m_wdata = 6'd20; mn_wr = 1'b1;
        @(negedge clk);
        mn_wr = 1'b0;
        chk("R9 n", div_n_o, 500);
        chk("R9 m", div_m_o, 20);
        set_pins(5, 0);
        cyc(1);
        chk("R9 n held on code change", div_n_o, 500);
        chk("R10 pulse on code change", config_changed_o, 1);
        cyc(1);
        chk("R10 pulse ends", config_changed_o, 0);
        mn_wen = 1'b0; mn_wr = 1'b1;
        @(negedge clk);
        mn_wr = 1'b0;
        chk("R9 override off", div_n_o, 205);
        for (int c = 15; c >= 0; c -= 3) begin
            set_pins(c, 1);
            cyc(1);
        end
        cyc(2);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule